// File: doc/BRIEF.md
# ISA Register Write Legalizer

This block keeps the machine ISA register of a hart: one bit per extension letter in the low bits and a base-width field in the two most significant bits. Software writes arrive as a data word with a write enable. The block decides whether the write is accepted at all, reduces an accepted word to a value the hart can support, stores it, and signals the instruction fetch side when the stored value has changed.

A write can be rejected as a whole. This happens when writes are disabled, when the word names neither base integer set, or when it names the embedded base. An accepted word keeps only the letters that the hart supports and that the block knows. Double precision is dropped when single precision is absent. Compressed support is dropped when the next instruction address is not on a 4-byte boundary. The base-width field always keeps its stored value.

Control is a two-state machine. `ST_IDLE` means no flush is pending. `ST_FLUSH` drives the flush pulse for the cycle that follows a value change. The machine takes the transition `IDLE->FLUSH` or `FLUSH->FLUSH` on an accepted write whose legal value differs from the stored value. It takes `FLUSH->IDLE` or stays in `IDLE->IDLE` on every other cycle.

Top module: `isa_reg_legalizer`

## Requirements
- R1: While `wr_allow` is 0, a write changes nothing and raises no flush.
- R2: A write word with neither bit 8 (I) nor bit 4 (E) set is dropped entirely.
- R3: A write word with bit 4 (E) set is dropped entirely.
- R4: An accepted word is ANDed with `hart_mask`. It is then limited to the letter bits A=0, C=2, D=3, E=4, F=5, I=8, M=12, S=18 and U=20. All other bits below the base-width field read 0.
- R5: If bit 3 (D) survives R4 while bit 5 (F) does not, bit 3 is cleared.
- R6: If bit 2 (C) survives and `next_pc[1:0]` is not 0, bit 2 is cleared.
- R7: The base-width field `isa_value[XLEN-1:XLEN-2]` is never changed by a write.
- R8: `icache_flush` is 1 for exactly the one cycle after an accepted write whose legal value differs from the stored value, and 0 otherwise.
- R9: Reset (async, active low) loads `RESET_VAL` (default 0x40141105: base field 1 plus I, M, A, C, S and U) and clears the flush.
- R10: While `wr_en` is 0, the stored value and the flush are unaffected by the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Word software writes |
| hart_mask | input | XLEN | Letters this hart supports |
| wr_allow | input | 1 | Writes permitted when 1 |
| next_pc | input | XLEN | Address of the next instruction |
| isa_value | output | XLEN | Stored ISA register |
| icache_flush | output | 1 | One-cycle pulse after a value change |

## Verification
Both results of a write fall due on the first rising edge after the write is presented. The new `isa_value` and the `icache_flush` pulse appear together, and the pulse is gone one edge later. The bench drives every vector on a falling edge and samples half a period after the next rising edge. It then checks the pulse again one more cycle on, to confirm it lasts only one cycle. Dropped writes are checked at the same point, against the value stored before them.

// File: rtl/isa_legal_pkg.sv
package isa_legal_pkg;
    localparam int BIT_A = 0;
    localparam int BIT_C = 2;
    localparam int BIT_D = 3;
    localparam int BIT_E = 4;
    localparam int BIT_F = 5;
    localparam int BIT_I = 8;
    localparam int BIT_M = 12;
    localparam int BIT_S = 18;
    localparam int BIT_U = 20;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } flush_state_e;
endpackage

// File: rtl/isa_write_filter.sv
module isa_write_filter
    import isa_legal_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] hart_mask,
    input  logic [XLEN-1:0] cur_isa,
    input  logic [XLEN-1:0] next_pc,
    input  logic            wr_allow,
    output logic            accept,
    output logic [XLEN-1:0] legal_value
);
    localparam int BASE_LO = XLEN - 2;

    function automatic logic [XLEN-1:0] known_letters();
        logic [XLEN-1:0] k;
        k = '0;
        k[BIT_A] = 1'b1;
        k[BIT_C] = 1'b1;
        k[BIT_D] = 1'b1;
        k[BIT_E] = 1'b1;
        k[BIT_F] = 1'b1;
        k[BIT_I] = 1'b1;
        k[BIT_M] = 1'b1;
        k[BIT_S] = 1'b1;
        k[BIT_U] = 1'b1;
        return k;
    endfunction

    localparam logic [XLEN-1:0] KEEP = known_letters();

    logic [XLEN-1:0] trimmed;

    always_comb begin
        accept  = wr_allow && wr_data[BIT_I] && !wr_data[BIT_E];
        trimmed = wr_data & hart_mask & KEEP;
        if (!trimmed[BIT_F]) begin
            trimmed[BIT_D] = 1'b0;
        end
        if (trimmed[BIT_C] && (next_pc[1:0] != 2'b00)) begin
            trimmed[BIT_C] = 1'b0;
        end
        legal_value = {cur_isa[XLEN-1:BASE_LO], trimmed[BASE_LO-1:0]};
    end
endmodule

// File: rtl/isa_flush_fsm.sv
module isa_flush_fsm
    import isa_legal_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [XLEN-1:0] next_value,
    output logic [XLEN-1:0] isa_q,
    output logic            flush
);
    flush_state_e state, state_nx;
    logic         differs;

    assign differs = commit && (next_value != isa_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = differs ? ST_FLUSH : ST_IDLE;
            ST_FLUSH: state_nx = differs ? ST_FLUSH : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            isa_q <= RESET_VAL;
        end else begin
            state <= state_nx;
            if (differs) begin
                isa_q <= next_value;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_FLUSH: flush = 1'b1;
            default:  flush = 1'b0;
        endcase
    end
endmodule

// File: rtl/isa_reg_legalizer.sv
module isa_reg_legalizer
    import isa_legal_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VAL = {2'b01, (XLEN-2)'('h141105)}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] hart_mask,
    input  logic            wr_allow,
    input  logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] isa_value,
    output logic            icache_flush
);
    logic            accept;
    logic [XLEN-1:0] legal_value;

    isa_write_filter #(.XLEN(XLEN)) u_filter (
        .wr_data     (wr_data),
        .hart_mask   (hart_mask),
        .cur_isa     (isa_value),
        .next_pc     (next_pc),
        .wr_allow    (wr_allow),
        .accept      (accept),
        .legal_value (legal_value)
    );

    isa_flush_fsm #(.XLEN(XLEN), .RESET_VAL(RESET_VAL)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (wr_en && accept),
        .next_value (legal_value),
        .isa_q      (isa_value),
        .flush      (icache_flush)
    );
endmodule

// File: rtl/isa_reg_legalizer_chk.sv
module isa_reg_legalizer_chk
    import isa_legal_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [XLEN-1:0] wr_data,
    input logic            wr_allow,
    input logic [XLEN-1:0] next_pc,
    input logic [XLEN-1:0] isa_value,
    input logic            icache_flush
);
    localparam logic [XLEN-1:0] ALLOWED =
        {2'b11, (XLEN-2)'('h14113D)};

    assert_drop_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allow) |=> ($stable(isa_value) && !icache_flush));

    assert_drop_no_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_I] && !wr_data[BIT_E]) |=> ($stable(isa_value) && !icache_flush));

    assert_drop_embedded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_E]) |=> ($stable(isa_value) && !icache_flush));

    assert_only_letters_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(isa_value) |-> ((isa_value & ~ALLOWED) == '0));

    assert_d_needs_f_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(isa_value) |-> !(isa_value[BIT_D] && !isa_value[BIT_F]));

    assert_c_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (next_pc[1:0] != 2'b00)) |=> ($stable(isa_value) || !isa_value[BIT_C]));

    assert_base_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(isa_value[XLEN-1:XLEN-2]));

    assert_flush_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(isa_value) |-> icache_flush);

    assert_flush_only_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        icache_flush |-> !$stable(isa_value));

    assert_idle_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(isa_value) && !icache_flush));
endmodule

bind isa_reg_legalizer isa_reg_legalizer_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .wr_allow     (wr_allow),
    .next_pc      (next_pc),
    .isa_value    (isa_value),
    .icache_flush (icache_flush)
);

// File: tb/sim_isa_reg_legalizer.sv
module sim_isa_reg_legalizer;
    localparam int NV = 13;
    localparam logic [31:0] RST_EXP = 32'h4014_1105;

    localparam logic        V_ALLOW [NV] = '{1,1,1,1,1,1,1,1,0,1,1,1,1};
    localparam logic [31:0] V_DATA  [NV] = '{
        32'h0000_112D, 32'h0000_112D, 32'h0000_110D, 32'h0000_1105,
        32'h0000_1105, 32'hC000_1105, 32'h0000_1011, 32'h0000_1004,
        32'h0000_0100, 32'hFFFF_FEEF, 32'hFFFF_FFFF, 32'h3FFF_FFEF,
        32'h0014_112D};
    localparam logic [31:0] V_MASK  [NV] = '{
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h0000_1100};
    localparam logic [31:0] V_PC    [NV] = '{
        32'h0, 32'h0, 32'h0, 32'h2, 32'h4, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h6};
    localparam logic [31:0] V_EXP   [NV] = '{
        32'h4000_112D, 32'h4000_112D, 32'h4000_1105, 32'h4000_1101,
        32'h4000_1105, 32'h4000_1105, 32'h4000_1105, 32'h4000_1105,
        32'h4000_1105, 32'h4000_1105, 32'h4000_1105, 32'h4014_112D,
        32'h4000_1100};
    localparam logic        V_FL    [NV] = '{1,0,1,1,1,0,0,0,0,0,0,1,1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] hart_mask = '1;
    logic        wr_allow = 1'b1;
    logic [31:0] next_pc = '0;
    logic [31:0] isa_value;
    logic        icache_flush;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    string v_req [NV] = '{"R4", "R8", "R5", "R6", "R6", "R7", "R3",
                          "R2", "R1", "R2", "R3", "R4", "R4"};

    always #4 clk = ~clk;

    isa_reg_legalizer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .hart_mask    (hart_mask),
        .wr_allow     (wr_allow),
        .next_pc      (next_pc),
        .isa_value    (isa_value),
        .icache_flush (icache_flush)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", isa_value, RST_EXP);
        check("R9", {31'b0, icache_flush}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", isa_value, RST_EXP);

        for (int i = 0; i < NV; i++) begin
            wr_en     = 1'b1;
            wr_allow  = V_ALLOW[i];
            wr_data   = V_DATA[i];
            hart_mask = V_MASK[i];
            next_pc   = V_PC[i];
            @(posedge clk);
            @(negedge clk);
            check(v_req[i], isa_value, V_EXP[i]);
            check("R8", {31'b0, icache_flush}, {31'b0, V_FL[i]});
        end

        // R10: strobe low with a word that would change the value
        wr_en     = 1'b0;
        wr_allow  = 1'b1;
        hart_mask = '1;
        wr_data   = 32'h0000_1105;
        next_pc   = '0;
        @(posedge clk);
        @(negedge clk);
        check("R10", isa_value, 32'h4000_1100);
        check("R8", {31'b0, icache_flush}, 32'h0);

        // R8: a single changing write gives a single-cycle pulse
        wr_en   = 1'b1;
        wr_data = 32'h0000_1101;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", isa_value, 32'h4000_1101);
        check("R8", {31'b0, icache_flush}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R8", {31'b0, icache_flush}, 32'h0);
        check("R10", isa_value, 32'h4000_1101);

        // R9: reset during operation restores the default
        wr_en   = 1'b1;
        wr_data = 32'h0000_112D;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", isa_value, RST_EXP);
        check("R9", {31'b0, icache_flush}, 32'h0);
        wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", isa_value, RST_EXP);

        done = 1'b1;
        summary();
    end
endmodule